// File: doc/BRIEF.md
# Infrared Carrier and Modulation Timer

This block drives and timestamps a low-speed infrared link. A carrier generator makes a square wave whose high and low phases are programmed independently in clock cycles. A single up/down counter does the modulation work: in transmit it counts each interval down from a programmed modulation time. For the length of each interval it lets either the carrier or a low idle level through to the transmit pin, as the data bit chooses. In receive the same counter counts up and records its value whenever a chosen edge arrives on the synchronized receive pin.

When the block is disabled the transmit pin and its output enable come straight from two manual control inputs, so firmware can bit-bang the pin without the timer. A rollover of the counter from all ones to zero in receive sets a sticky overflow flag, and an interrupt output follows that flag when the interrupt enable is set.

Top module: `ir_mod_timer`

## Requirements
- R1: While `en` is 0, `tx_pin` equals `man_level`, `tx_oe` equals `man_oe`, the counter reads 0 one cycle later, and the overflow flag is cleared one cycle later; after reset all outputs read 0.
- R2: When the carrier turns on it starts with its high phase; the high phase lasts `car_hi`+1 cycles and the low phase `car_lo`+1 cycles, repeating, so a value of 0 still gives a one-cycle phase.
- R3: In transmit (`rx_mode`=0), the first enabled clock loads `mod_time` into the counter; it then falls by one per cycle, and after it reads 0 the next clock reloads `mod_time`, so each interval lasts `mod_time`+1 cycles.
- R4: In transmit, `tx_data` is sampled at every load or reload; a sampled 1 puts the carrier on `tx_pin` for that interval, a sampled 0 holds `tx_pin` low; `tx_oe` is 1 throughout transmit.
- R5: `ivl_done` is high for the one cycle after each reload from zero, and stays low after the first load.
- R6: In receive (`rx_mode`=1), the counter starts from 0 and rises by one per cycle (reading 1 in the first enabled cycle), and `tx_pin` and `tx_oe` are both 0.
- R7: `rx_pin` passes through two synchronizing flops; `edge_sel` selects captured edges as 00 none, 01 rising, 10 falling, 11 both; a selected edge placed on `rx_pin` after clock T shows in `capture` in cycle T+3 as the counter value of cycle T+2, and unselected edges leave `capture` unchanged.
- R8: With `rx_reload`=1, a captured edge sets the counter to 0 in the same cycle `capture` updates; with `rx_reload`=0 the counter keeps counting.
- R9: A receive rollover from FFFFh to 0 sets `ovf_flag` in the cycle the counter reads 0, and the flag stays set while `en` is 1.
- R10: `irq` is 1 exactly when `ovf_flag` and `ovf_ie` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Timer enable |
| rx_mode | input | 1 | 1 selects receive, 0 transmit |
| car_hi | input | 8 | Carrier high phase length minus one |
| car_lo | input | 8 | Carrier low phase length minus one |
| mod_time | input | 16 | Transmit interval length minus one |
| tx_data | input | 1 | Data bit sampled at each interval start |
| edge_sel | input | 2 | Receive edge selection |
| rx_reload | input | 1 | Reset counter to zero on capture |
| ovf_ie | input | 1 | Overflow interrupt enable |
| man_level | input | 1 | Manual transmit pin level when disabled |
| man_oe | input | 1 | Manual transmit output enable when disabled |
| rx_pin | input | 1 | Receive pin, asynchronous |
| tx_pin | output | 1 | Transmit pin level |
| tx_oe | output | 1 | Transmit pin output enable |
| count | output | 16 | Current counter value |
| capture | output | 16 | Counter value taken at the last selected edge |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt |
| ivl_done | output | 1 | One-cycle pulse at each transmit reload |

## Verification
The manual pin path and the interrupt gate are combinational, so they are checked in the cycle after the input moves. The counter, carrier phase and interval pulse are registered: enabling at one clock gives the loaded value and the first carrier high right after it, and a reload from zero shows one clock later together with `ivl_done`. A receive edge needs two synchronizer flops plus the capture register, so `capture` is due three cycles after the pin changes. The bench stamps every expected item with the absolute cycle it is due, and the monitor compares only in that cycle, flagging any item whose cycle went by unchecked.

// File: rtl/ir_mod_pkg.sv
`timescale 1ns/1ps
package ir_mod_pkg;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   // Decide whether the transition prv -> cur is one the selection wants.
   function automatic logic edge_match(edge_sel_e sel, logic cur, logic prv);
      logic hit;
      case (sel)
         EDGE_RISE: hit = cur & ~prv;
         EDGE_FALL: hit = ~cur & prv;
         EDGE_BOTH: hit = cur ^ prv;
         default:   hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/ir_carrier_gen.sv
`timescale 1ns/1ps
module ir_carrier_gen #(
   parameter int PH_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PH_W-1:0] hi_len,
   input  logic [PH_W-1:0] lo_len,
   output logic            carrier
);

   logic            in_high;
   logic [PH_W-1:0] ph_cnt;
   logic [PH_W-1:0] ph_end;

   assign ph_end = in_high ? hi_len : lo_len;

   // Phase is parked at the start of a high phase whenever run is low.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_high <= 1'b1;
         ph_cnt  <= '0;
      end else if (!run) begin
         in_high <= 1'b1;
         ph_cnt  <= '0;
      end else if (ph_cnt == ph_end) begin
         in_high <= ~in_high;
         ph_cnt  <= '0;
      end else begin
         ph_cnt  <= ph_cnt + PH_W'(1);
      end
   end

   assign carrier = run & in_high;

endmodule

// File: rtl/ir_edge_detect.sv
`timescale 1ns/1ps
module ir_edge_detect
   import ir_mod_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] sel,
   output logic       edge_hit
);

   // STAGES synchronizer flops followed by one history flop.
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], pin};
   end

   assign edge_hit = edge_match(edge_sel_e'(sel), chain[STAGES-1], chain[STAGES]);

endmodule

// File: rtl/ir_mod_counter.sv
`timescale 1ns/1ps
module ir_mod_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         rx_mode,
   input  logic [W-1:0] load_val,
   input  logic         tx_data,
   input  logic         edge_hit,
   input  logic         rx_reload,
   output logic [W-1:0] count,
   output logic [W-1:0] capture,
   output logic         ovf,
   output logic         ivl_done,
   output logic         cur_data,
   output logic         loaded
);

   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   logic first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         capture  <= '0;
         ovf      <= 1'b0;
         ivl_done <= 1'b0;
         cur_data <= 1'b0;
         first    <= 1'b1;
      end else if (!en) begin
         count    <= '0;
         ovf      <= 1'b0;
         ivl_done <= 1'b0;
         cur_data <= 1'b0;
         first    <= 1'b1;
      end else if (rx_mode) begin
         ivl_done <= 1'b0;
         first    <= 1'b0;
         if (edge_hit) begin
            capture <= count;
            count   <= rx_reload ? '0 : count + W'(1);
         end else begin
            count   <= count + W'(1);
         end
         if (count == CNT_MAX && !(edge_hit && rx_reload))
            ovf <= 1'b1;
      end else if (first) begin
         count    <= load_val;
         cur_data <= tx_data;
         first    <= 1'b0;
         ivl_done <= 1'b0;
      end else if (count == '0) begin
         count    <= load_val;
         cur_data <= tx_data;
         ivl_done <= 1'b1;
      end else begin
         count    <= count - W'(1);
         ivl_done <= 1'b0;
      end
   end

   assign loaded = ~first;

endmodule

// File: rtl/ir_mod_timer.sv
`timescale 1ns/1ps
module ir_mod_timer #(
   parameter int CNT_W       = 16,
   parameter int PH_W        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             rx_mode,
   input  logic [PH_W-1:0]  car_hi,
   input  logic [PH_W-1:0]  car_lo,
   input  logic [CNT_W-1:0] mod_time,
   input  logic             tx_data,
   input  logic [1:0]       edge_sel,
   input  logic             rx_reload,
   input  logic             ovf_ie,
   input  logic             man_level,
   input  logic             man_oe,
   input  logic             rx_pin,
   output logic             tx_pin,
   output logic             tx_oe,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] capture,
   output logic             ovf_flag,
   output logic             irq,
   output logic             ivl_done
);

   generate
      if (CNT_W < 4) begin : g_bad_cnt_w
         $error("CNT_W must be at least 4");
      end
      if (PH_W < 1) begin : g_bad_ph_w
         $error("PH_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic edge_hit;
   logic cur_data;
   logic loaded;
   logic car_run;
   logic carrier;

   ir_edge_detect #(.STAGES(SYNC_STAGES)) edge_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (rx_pin),
      .sel      (edge_sel),
      .edge_hit (edge_hit)
   );

   ir_mod_counter #(.W(CNT_W)) cnt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .rx_mode   (rx_mode),
      .load_val  (mod_time),
      .tx_data   (tx_data),
      .edge_hit  (edge_hit),
      .rx_reload (rx_reload),
      .count     (count),
      .capture   (capture),
      .ovf       (ovf_flag),
      .ivl_done  (ivl_done),
      .cur_data  (cur_data),
      .loaded    (loaded)
   );

   assign car_run = en & ~rx_mode & loaded & cur_data;

   ir_carrier_gen #(.PH_W(PH_W)) car_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (car_run),
      .hi_len  (car_hi),
      .lo_len  (car_lo),
      .carrier (carrier)
   );

   always_comb begin
      if (!en) begin
         tx_pin = man_level;
         tx_oe  = man_oe;
      end else if (rx_mode) begin
         tx_pin = 1'b0;
         tx_oe  = 1'b0;
      end else begin
         tx_pin = carrier;
         tx_oe  = 1'b1;
      end
   end

   assign irq = ovf_flag & ovf_ie;

endmodule

// File: rtl/ir_mod_timer_chk.sv
`timescale 1ns/1ps
module ir_mod_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             rx_mode,
   input logic             ovf_ie,
   input logic             tx_oe,
   input logic [CNT_W-1:0] count,
   input logic             ovf_flag,
   input logic             irq,
   input logic             ivl_done
);

   AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (count == '0 && !ovf_flag && !ivl_done));  // R1

   AST_TX_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !rx_mode && $past(en) && !$past(rx_mode) && count != '0)
      |=> (count == $past(count) - CNT_W'(1)));  // R3

   AST_DONE_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ivl_done |-> ($past(count) == '0));  // R5

   AST_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && rx_mode) |-> !tx_oe);  // R6

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && en) |=> ovf_flag);  // R9

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ovf_flag && ovf_ie));  // R10

endmodule

bind ir_mod_timer ir_mod_timer_chk #(.CNT_W(CNT_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .rx_mode  (rx_mode),
   .ovf_ie   (ovf_ie),
   .tx_oe    (tx_oe),
   .count    (count),
   .ovf_flag (ovf_flag),
   .irq      (irq),
   .ivl_done (ivl_done)
);

// File: tb/ir_mod_timer_tb_top.sv
`timescale 1ns/1ps
module ir_mod_timer_tb_top;

   localparam int S_PIN = 0, S_OE = 1, S_CNT = 2, S_CAP = 3, S_OVF = 4, S_IRQ = 5, S_IVL = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0, rx_mode = 1'b0, tx_data = 1'b0, rx_reload = 1'b0;
   logic        ovf_ie = 1'b0, man_level = 1'b0, man_oe = 1'b0, rx_pin = 1'b0;
   logic [7:0]  car_hi = '0, car_lo = '0;
   logic [15:0] mod_time = '0;
   logic [1:0]  edge_sel = '0;
   logic        tx_pin, tx_oe, ovf_flag, irq, ivl_done;
   logic [15:0] count, capture;

   int cyc = 0;
   int nchk = 0;
   int nfail = 0;
   bit done = 0;

   typedef struct { int cyc; int sig; int val; string req; } exp_t;
   exp_t q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ir_mod_timer dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .rx_mode(rx_mode), .car_hi(car_hi),
      .car_lo(car_lo), .mod_time(mod_time), .tx_data(tx_data), .edge_sel(edge_sel),
      .rx_reload(rx_reload), .ovf_ie(ovf_ie), .man_level(man_level), .man_oe(man_oe),
      .rx_pin(rx_pin), .tx_pin(tx_pin), .tx_oe(tx_oe), .count(count), .capture(capture),
      .ovf_flag(ovf_flag), .irq(irq), .ivl_done(ivl_done)
   );

   function automatic int sig_val(int s);
      case (s)
         S_PIN:   return int'(tx_pin);
         S_OE:    return int'(tx_oe);
         S_CNT:   return int'(count);
         S_CAP:   return int'(capture);
         S_OVF:   return int'(ovf_flag);
         S_IRQ:   return int'(irq);
         default: return int'(ivl_done);
      endcase
   endfunction

   task automatic push(int c, int s, int v, string r);
      exp_t e;
      e.cyc = c; e.sig = s; e.val = v; e.req = r;
      q.push_back(e);
   endtask

   task automatic wait_cyc(int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", nfail, nchk);
         $finish;
      end
   endtask

   // Monitor: compares each expected item in the cycle it is due.
   always @(posedge clk) begin
      #1;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         exp_t e;
         int act;
         e = q.pop_front();
         act = sig_val(e.sig);
         nchk++;
         if (e.cyc < cyc) begin
            nfail++;
            $display("FAIL %s: item for cycle %0d missed at %0d, sig %0d actual %0h expected %0h",
                     e.req, e.cyc, cyc, e.sig, act, e.val);
         end else if (act != e.val) begin
            nfail++;
            $display("FAIL %s: cycle %0d sig %0d actual %0h expected %0h",
                     e.req, cyc, e.sig, act, e.val);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      report();
   end

   initial begin
      int c1;
      int m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      c1 = cyc + 1;
      push(c1, S_PIN, 0, "R1"); push(c1, S_OE, 0, "R1"); push(c1, S_CNT, 0, "R1");
      push(c1, S_CAP, 0, "R1"); push(c1, S_OVF, 0, "R1"); push(c1, S_IRQ, 0, "R1");
      push(c1, S_IVL, 0, "R1");
      wait_cyc(c1);

      // R1: manual pin control while disabled
      man_level = 1'b1; man_oe = 1'b1;
      push(cyc + 1, S_PIN, 1, "R1"); push(cyc + 1, S_OE, 1, "R1");
      wait_cyc(cyc + 1);
      man_level = 1'b0;
      push(cyc + 1, S_PIN, 0, "R1"); push(cyc + 1, S_OE, 1, "R1");
      wait_cyc(cyc + 1);
      man_level = 1'b1;

      // R2 R3 R4 R5: transmit, data 1 then 0 then 1, high 3 cycles, low 2
      m = 10;
      car_hi = 8'd2; car_lo = 8'd1; mod_time = 16'(m); tx_data = 1'b1; rx_mode = 1'b0;
      en = 1'b1;
      c1 = cyc + 1;
      for (int k = 0; k <= 3*m + 5; k++) begin
         int ep;
         if (k <= m)            ep = ((k % 5) <= 2) ? 1 : 0;
         else if (k <= 2*m + 1) ep = 0;
         else                   ep = (((k - 2*m - 2) % 5) <= 2) ? 1 : 0;
         push(c1 + k, S_PIN, ep, (k <= m) ? "R2" : "R4");
         push(c1 + k, S_OE, 1, "R4");
         if (k <= m)      push(c1 + k, S_CNT, m - k, "R3");
         if (k == m + 1)  push(c1 + k, S_CNT, m, "R3");
         if (k <= 2*m + 2)
            push(c1 + k, S_IVL, (k == m + 1 || k == 2*m + 2) ? 1 : 0, "R5");
      end
      wait_cyc(c1);
      tx_data = 1'b0;
      wait_cyc(c1 + m + 1);
      tx_data = 1'b1;
      wait_cyc(c1 + 3*m + 5);
      en = 1'b0;
      push(cyc + 1, S_CNT, 0, "R1"); push(cyc + 1, S_PIN, 1, "R1"); push(cyc + 1, S_OE, 1, "R1");
      wait_cyc(cyc + 2);

      // R2: zero-length high phase gives one cycle high, then four low
      car_hi = 8'd0; car_lo = 8'd3; mod_time = 16'd20; tx_data = 1'b1;
      en = 1'b1;
      c1 = cyc + 1;
      for (int k = 0; k < 16; k++) push(c1 + k, S_PIN, ((k % 5) == 0) ? 1 : 0, "R2");
      wait_cyc(c1 + 16);
      en = 1'b0;
      wait_cyc(cyc + 2);

      // R6 R7 R8: receive
      rx_mode = 1'b1; edge_sel = 2'b01; rx_reload = 1'b0; rx_pin = 1'b0;
      en = 1'b1;
      c1 = cyc + 1;
      push(c1, S_CNT, 1, "R6"); push(c1, S_OE, 0, "R6"); push(c1, S_PIN, 0, "R6");
      push(c1 + 3, S_CNT, 4, "R6");
      wait_cyc(c1 + 5);
      rx_pin = 1'b1;                                   // rising, selected
      push(c1 + 7, S_CAP, 0, "R7"); push(c1 + 8, S_CAP, 8, "R7");
      wait_cyc(c1 + 15);
      rx_pin = 1'b0;                                   // falling, not selected
      push(c1 + 18, S_CAP, 8, "R7"); push(c1 + 18, S_CNT, 19, "R8");
      push(c1 + 20, S_CAP, 8, "R7");
      wait_cyc(c1 + 25);
      edge_sel = 2'b10; rx_reload = 1'b1;
      wait_cyc(c1 + 30);
      rx_pin = 1'b1;                                   // rising, not selected
      push(c1 + 34, S_CAP, 8, "R7");
      wait_cyc(c1 + 40);
      rx_pin = 1'b0;                                   // falling, selected, reload
      push(c1 + 43, S_CAP, 43, "R7"); push(c1 + 43, S_CNT, 0, "R8");
      push(c1 + 44, S_CNT, 1, "R8");
      wait_cyc(c1 + 46);
      edge_sel = 2'b11; rx_reload = 1'b0;
      wait_cyc(c1 + 50);
      rx_pin = 1'b1;                                   // both: rising
      push(c1 + 53, S_CAP, 9, "R7");
      wait_cyc(c1 + 60);
      rx_pin = 1'b0;                                   // both: falling
      push(c1 + 63, S_CAP, 19, "R7"); push(c1 + 63, S_CNT, 20, "R8");
      wait_cyc(c1 + 65);
      edge_sel = 2'b00;
      wait_cyc(c1 + 70);
      rx_pin = 1'b1;                                   // none selected
      push(c1 + 74, S_CAP, 19, "R7"); push(c1 + 74, S_CNT, 31, "R7");
      wait_cyc(c1 + 76);
      en = 1'b0;
      push(cyc + 1, S_CNT, 0, "R1"); push(cyc + 1, S_CAP, 19, "R7");
      wait_cyc(cyc + 1);
      rx_pin = 1'b0;
      wait_cyc(cyc + 8);

      // R9 R10: receive rollover
      edge_sel = 2'b00; ovf_ie = 1'b0;
      en = 1'b1;
      c1 = cyc + 1;
      push(c1 + 65534, S_CNT, 16'hFFFF, "R9"); push(c1 + 65534, S_OVF, 0, "R9");
      push(c1 + 65535, S_CNT, 0, "R9");        push(c1 + 65535, S_OVF, 1, "R9");
      push(c1 + 65535, S_IRQ, 0, "R10");
      push(c1 + 65537, S_OVF, 1, "R9");        push(c1 + 65537, S_IRQ, 1, "R10");
      push(c1 + 65541, S_OVF, 0, "R1");        push(c1 + 65541, S_IRQ, 0, "R10");
      push(c1 + 65541, S_CNT, 0, "R1");
      wait_cyc(c1 + 65536);
      ovf_ie = 1'b1;
      wait_cyc(c1 + 65540);
      en = 1'b0;

      while (q.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      report();
   end

endmodule